// File: doc/BRIEF.md
# Four-Port Byte-Lane Shared Memory

This block is a word-addressed storage array shared by four ports. Each port runs on its own clock and has an address, an 18-bit write bus, an 18-bit read bus, a read/write select, an output enable and a pair of chip selects of opposite polarity. Every word is split into two 9-bit lanes, and each port can write or present either lane on its own. Read data leaves through a register, so a read issued on one rising edge is on the port's read bus after that edge.

The port is selected when its low-active select is low and its high-active select is high. A port that was deselected on an edge must be selected for one edge before its read bus is driven again. The read bus is not a tri-state pin. Each lane has a drive flag, and a disabled lane reads as zero. The pad ring uses the drive flags as its output enables.

Any number of ports may read one word together. A read and a write to the same word in overlapping cycles, or two writes to it, leave that word undefined. No other word is affected. The word count is 2^ADDR_W. ADDR_W = 16 gives the full 65536-word array.

Top module: `quad_lane_ram`

## Requirements
- R1: A word has two 9-bit lanes. Lane 0 is bits 8:0 and is enabled by `lane_ni[p][0]` low. Lane 1 is bits 17:9 and is enabled by `lane_ni[p][1]` low. A write stores only the enabled lanes, and the other lanes keep their contents. A write with both lanes disabled changes nothing.
- R2: Port p is selected on a rising edge of `clk_i[p]` only when `ce0_ni[p]` is 0 and `ce1_i[p]` is 1. A write on a deselected edge has no effect on the array.
- R3: A read (`rnw_i[p]` = 1, port selected) on edge k puts the addressed word into the port's read register after edge k. The register holds that word until the next read.
- R4: `rdrv_o[p][l]` is 1 only when all of these hold: edge k was a selected read, lane l was enabled on edge k, and `oe_ni[p]` is 0 now. While `rdrv_o[p][l]` is 0, that lane of `rdata_o[p]` is 0.
- R5: On the first selected edge after a deselected edge, or after reset, a read produces no drive. The next selected read is driven.
- R6: `oe_ni[p]` acts without a clock. While it is 1, both drive flags and the read bus of port p are 0. Clearing it shows the held read at once.
- R7: After a write edge or a deselected edge, the port drives nothing.
- R8: A word written through any port is returned by every other port once that write edge has passed. All four ports may read one word together and each gets the same value.
- R9: Two ports writing one word in overlapping cycles leave that word undefined. Every other word keeps its value.
- R10: While `rst_ni` is 0, every `rdrv_o` and `rdata_o` is 0. The storage itself is not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | NPORTS | One clock per port |
| rst_ni | input | 1 | Asynchronous reset of the port registers, active low |
| addr_i | input | NPORTS x ADDR_W | Word address per port |
| wdata_i | input | NPORTS x 18 | Write data per port |
| rnw_i | input | NPORTS | 1 = read, 0 = write |
| lane_ni | input | NPORTS x 2 | Lane enables, active low (bit 0 = bits 8:0) |
| ce0_ni | input | NPORTS | Chip select, active low |
| ce1_i | input | NPORTS | Chip select, active high |
| oe_ni | input | NPORTS | Output enable, active low |
| rdata_o | output | NPORTS x 18 | Registered read data, disabled lanes zero |
| rdrv_o | output | NPORTS x 2 | Per-lane drive flag for the pad ring |

## Verification
The timing rules, in order:
- A read's data and drive flags belong to the edge on which the read was sampled. They are due one half period of that port's own clock later, and the bench samples them on that port's falling edge.
- The output enable needs no edge. Its effect is sampled one nanosecond after the change.
- A write is visible to any port whose sampling edge comes after the writer's edge. The bench therefore reads back only after the write task has passed its falling edge.

Every stimulus is driven on a falling edge, away from the edges that sample it. A bench flagger marks as tainted any word that two ports wrote in overlapping windows, and those words are not compared.

// File: rtl/qlr_pkg.sv
package qlr_pkg;
  typedef enum logic [1:0] {
    OP_OFF   = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } port_op_e;

  function automatic port_op_e decode_op(input logic ce0_n, input logic ce1, input logic rnw);
    if (ce0_n || !ce1) return OP_OFF;
    return rnw ? OP_READ : OP_WRITE;
  endfunction
endpackage

// File: rtl/qlr_bank.sv
module qlr_bank #(
  parameter int NPORTS = 4,
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int WORD_W = LANE_W * LANES,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic                           clk_i,
  input  logic                           wr_en_i,
  input  logic [LANES-1:0]               wr_lane_i,
  input  logic [ADDR_W-1:0]              waddr_i,
  input  logic [WORD_W-1:0]              wword_i,
  input  logic [NPORTS-1:0][ADDR_W-1:0]  raddr_i,
  output logic [NPORTS-1:0][WORD_W-1:0]  rword_o
);
  // One storage column per lane, written only by the owning port's clock.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_lane_i[l]) store[waddr_i] <= wword_i[l*LANE_W +: LANE_W];
    end

    for (genvar q = 0; q < NPORTS; q++) begin : g_rd
      assign rword_o[q][l*LANE_W +: LANE_W] = store[raddr_i[q]];
    end
  end
endmodule

// File: rtl/qlr_port_ctrl.sv
module qlr_port_ctrl
  import qlr_pkg::*;
#(
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int WORD_W = LANE_W * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce0_ni,
  input  logic              ce1_i,
  input  logic              rnw_i,
  input  logic              oe_ni,
  input  logic [LANES-1:0]  lane_ni,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic              wr_en_o,
  output logic [LANES-1:0]  wr_lane_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic [LANES-1:0]  rdrv_o
);
  port_op_e          op;
  logic              awake_q;
  logic [LANES-1:0]  drv_q;
  logic [WORD_W-1:0] data_q;

  assign op        = decode_op(ce0_ni, ce1_i, rnw_i);
  assign wr_en_o   = (op == OP_WRITE);
  assign wr_lane_o = ~lane_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      awake_q <= 1'b0;
      drv_q   <= '0;
      data_q  <= '0;
    end else begin
      awake_q <= (op != OP_OFF);
      drv_q   <= (op == OP_READ && awake_q) ? ~lane_ni : '0;
      if (op == OP_READ) data_q <= rd_word_i;
    end
  end

  assign rdrv_o = oe_ni ? '0 : drv_q;

  for (genvar l = 0; l < LANES; l++) begin : g_mask
    assign rdata_o[l*LANE_W +: LANE_W] = rdrv_o[l] ? data_q[l*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/quad_lane_ram.sv
module quad_lane_ram #(
  parameter int NPORTS = 4,
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int WORD_W = LANE_W * LANES
) (
  input  logic [NPORTS-1:0]              clk_i,
  input  logic                           rst_ni,
  input  logic [NPORTS-1:0][ADDR_W-1:0]  addr_i,
  input  logic [NPORTS-1:0][WORD_W-1:0]  wdata_i,
  input  logic [NPORTS-1:0]              rnw_i,
  input  logic [NPORTS-1:0][LANES-1:0]   lane_ni,
  input  logic [NPORTS-1:0]              ce0_ni,
  input  logic [NPORTS-1:0]              ce1_i,
  input  logic [NPORTS-1:0]              oe_ni,
  output logic [NPORTS-1:0][WORD_W-1:0]  rdata_o,
  output logic [NPORTS-1:0][LANES-1:0]   rdrv_o
);
  // bank_rd[b][q]: content of bank b at the address of port q
  logic [NPORTS-1:0][NPORTS-1:0][WORD_W-1:0] bank_rd;
  logic [NPORTS-1:0][WORD_W-1:0]             rd_mix;
  logic [NPORTS-1:0][WORD_W-1:0]             wr_mix;
  logic [NPORTS-1:0]                         wr_en;
  logic [NPORTS-1:0][LANES-1:0]              wr_lane;

  // A word is the XOR of every bank at that address. A writer stores its data
  // XORed with the other banks, so the XOR of all banks becomes the new data.
  always_comb begin
    for (int q = 0; q < NPORTS; q++) begin
      rd_mix[q] = '0;
      wr_mix[q] = wdata_i[q];
      for (int b = 0; b < NPORTS; b++) begin
        rd_mix[q] = rd_mix[q] ^ bank_rd[b][q];
        if (b != q) wr_mix[q] = wr_mix[q] ^ bank_rd[b][q];
      end
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    qlr_port_ctrl #(.LANE_W(LANE_W), .LANES(LANES)) u_ctrl (
      .clk_i    (clk_i[p]),
      .rst_ni   (rst_ni),
      .ce0_ni   (ce0_ni[p]),
      .ce1_i    (ce1_i[p]),
      .rnw_i    (rnw_i[p]),
      .oe_ni    (oe_ni[p]),
      .lane_ni  (lane_ni[p]),
      .rd_word_i(rd_mix[p]),
      .wr_en_o  (wr_en[p]),
      .wr_lane_o(wr_lane[p]),
      .rdata_o  (rdata_o[p]),
      .rdrv_o   (rdrv_o[p])
    );

    qlr_bank #(.NPORTS(NPORTS), .ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_bank (
      .clk_i    (clk_i[p]),
      .wr_en_i  (wr_en[p]),
      .wr_lane_i(wr_lane[p]),
      .waddr_i  (addr_i[p]),
      .wword_i  (wr_mix[p]),
      .raddr_i  (addr_i),
      .rword_o  (bank_rd[p])
    );
  end
endmodule

// File: rtl/quad_lane_ram_chk.sv
module quad_lane_ram_chk #(
  parameter int NPORTS = 4,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int WORD_W = LANE_W * LANES
) (
  input logic [NPORTS-1:0]              clk_i,
  input logic                           rst_ni,
  input logic [NPORTS-1:0]              rnw_i,
  input logic [NPORTS-1:0][LANES-1:0]   lane_ni,
  input logic [NPORTS-1:0]              ce0_ni,
  input logic [NPORTS-1:0]              ce1_i,
  input logic [NPORTS-1:0]              oe_ni,
  input logic [NPORTS-1:0][WORD_W-1:0]  rdata_o,
  input logic [NPORTS-1:0][LANES-1:0]   rdrv_o
);
  for (genvar g = 0; g < NPORTS; g++) begin : g_p
    logic sel;
    assign sel = !ce0_ni[g] && ce1_i[g];

    // R7
    write_quiet_chk: assert property (@(posedge clk_i[g]) disable iff (!rst_ni)
      (sel && !rnw_i[g]) |=> (rdrv_o[g] == '0));

    // R7
    desel_quiet_chk: assert property (@(posedge clk_i[g]) disable iff (!rst_ni)
      !sel |=> (rdrv_o[g] == '0));

    // R5
    wake_quiet_chk: assert property (@(posedge clk_i[g]) disable iff (!rst_ni)
      (sel && !$past(sel)) |=> (rdrv_o[g] == '0));

    // R6
    oe_gate_chk: assert property (@(posedge clk_i[g]) disable iff (!rst_ni)
      oe_ni[g] |-> (rdrv_o[g] == '0 && rdata_o[g] == '0));

    for (genvar l = 0; l < LANES; l++) begin : g_l
      // R4
      lane_off_chk: assert property (@(posedge clk_i[g]) disable iff (!rst_ni)
        (sel && rnw_i[g] && lane_ni[g][l]) |=> !rdrv_o[g][l]);

      // R4
      lane_zero_chk: assert property (@(posedge clk_i[g]) disable iff (!rst_ni)
        !rdrv_o[g][l] |-> (rdata_o[g][l*LANE_W +: LANE_W] == '0));
    end
  end
endmodule

bind quad_lane_ram quad_lane_ram_chk #(.NPORTS(NPORTS), .LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .rnw_i  (rnw_i),
  .lane_ni(lane_ni),
  .ce0_ni (ce0_ni),
  .ce1_i  (ce1_i),
  .oe_ni  (oe_ni),
  .rdata_o(rdata_o),
  .rdrv_o (rdrv_o)
);

// File: tb/quad_lane_ram_bench.sv
module quad_lane_ram_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int AW = 10;
  localparam int DW = 18;

  logic [NP-1:0]          clk;
  logic                   rst_n;
  logic [NP-1:0][AW-1:0]  addr;
  logic [NP-1:0][DW-1:0]  wdata;
  logic [NP-1:0]          rnw;
  logic [NP-1:0][1:0]     lane_n;
  logic [NP-1:0]          ce0_n;
  logic [NP-1:0]          ce1;
  logic [NP-1:0]          oe_n;
  logic [NP-1:0][DW-1:0]  rdata;
  logic [NP-1:0][1:0]     rdrv;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [NP-1:0]         infl_wr;
  logic [NP-1:0][AW-1:0] infl_addr;
  bit tainted [int];

  quad_lane_ram u_quad_lane_ram (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .rnw_i(rnw),
    .lane_ni(lane_n), .ce0_ni(ce0_n), .ce1_i(ce1), .oe_ni(oe_n),
    .rdata_o(rdata), .rdrv_o(rdrv)
  );

  // Each port has its own period so the clocks drift against each other.
  for (genvar g = 0; g < NP; g++) begin : g_clk
    initial begin
      clk[g] = 1'b0;
      forever #((CLK_PERIOD + 2 * g) / 2.0) clk[g] = ~clk[g];
    end
  end

  typedef struct packed {
    logic [1:0]    port;
    logic          wr;
    logic [AW-1:0] addr;
    logic [1:0]    lane_n;
    logic [DW-1:0] data;
    logic [DW-1:0] exp;
    logic [1:0]    drv;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b1, 10'h005, 2'b00, 18'h2A5C3, 18'h00000, 2'b00}, // R7 write, no drive
    '{2'd1, 1'b0, 10'h005, 2'b00, 18'h00000, 18'h2A5C3, 2'b11}, // R8 R3 cross-port read
    '{2'd2, 1'b1, 10'h005, 2'b10, 18'h3FFFF, 18'h00000, 2'b00}, // R1 lane 0 only
    '{2'd3, 1'b0, 10'h005, 2'b00, 18'h00000, 18'h2A5FF, 2'b11}, // R1
    '{2'd3, 1'b1, 10'h005, 2'b01, 18'h00000, 18'h00000, 2'b00}, // R1 lane 1 only
    '{2'd0, 1'b0, 10'h005, 2'b00, 18'h00000, 18'h001FF, 2'b11}, // R1
    '{2'd1, 1'b0, 10'h005, 2'b01, 18'h00000, 18'h00000, 2'b10}, // R4 upper lane shown
    '{2'd1, 1'b0, 10'h005, 2'b10, 18'h00000, 18'h001FF, 2'b01}, // R4 lower lane shown
    '{2'd1, 1'b1, 10'h3FF, 2'b00, 18'h15555, 18'h00000, 2'b00}, // R8 top word
    '{2'd2, 1'b0, 10'h3FF, 2'b00, 18'h00000, 18'h15555, 2'b11}, // R8
    '{2'd0, 1'b1, 10'h000, 2'b00, 18'h3FFFF, 18'h00000, 2'b00}, // R8 bottom word
    '{2'd2, 1'b1, 10'h000, 2'b11, 18'h00000, 18'h00000, 2'b00}, // R1 no lanes
    '{2'd3, 1'b0, 10'h000, 2'b00, 18'h00000, 18'h3FFFF, 2'b11}, // R1 unchanged
    '{2'd0, 1'b1, 10'h006, 2'b00, 18'h0ABCD, 18'h00000, 2'b00}, // R9 neighbour
    '{2'd3, 1'b1, 10'h008, 2'b00, 18'h1F00F, 18'h00000, 2'b00}  // R9 neighbour
  };

  task automatic check(input string req, input logic [DW-1:0] act_d, input logic [DW-1:0] exp_d,
                       input logic [1:0] act_v, input logic [1:0] exp_v);
    checks++;
    if (act_d !== exp_d || act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: data %h drive %b, expected data %h drive %b", req, act_d, act_v, exp_d, exp_v);
    end
  endtask

  task automatic idle_port(input int p);
    ce0_n[p] = 1'b0; ce1[p] = 1'b1; rnw[p] = 1'b1; lane_n[p] = 2'b11;
  endtask

  task automatic run_op(input int p, input logic wr, input logic [AW-1:0] a, input logic [1:0] ln,
                        input logic [DW-1:0] d, output logic [DW-1:0] rd, output logic [1:0] dv);
    @(negedge clk[p]);
    ce0_n[p] = 1'b0; ce1[p] = 1'b1; rnw[p] = !wr; addr[p] = a; lane_n[p] = ln; wdata[p] = d;
    if (wr) begin
      for (int q = 0; q < NP; q++)
        if (q != p && infl_wr[q] && infl_addr[q] == a) tainted[int'(a)] = 1'b1;
      infl_wr[p] = 1'b1; infl_addr[p] = a;
    end
    @(posedge clk[p]);
    #1 infl_wr[p] = 1'b0;
    @(negedge clk[p]);
    rd = rdata[p]; dv = rdrv[p];
    idle_port(p);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] r0, r1, r2, r3;
    logic [1:0]    v0, v1, v2, v3;
    rst_n = 1'b0; infl_wr = '0; infl_addr = '0; oe_n = '0; addr = '0; wdata = '0;
    for (int p = 0; p < NP; p++) idle_port(p);
    #(CLK_PERIOD * 3 + 1);
    // R10 outputs quiet in reset
    check("R10", rdata, '0, rdrv[0] | rdrv[1] | rdrv[2] | rdrv[3], 2'b00);
    rst_n = 1'b1;
    #(CLK_PERIOD * 4);

    for (int i = 0; i < NV; i++) begin
      run_op(int'(VEC[i].port), VEC[i].wr, VEC[i].addr, VEC[i].lane_n, VEC[i].data, r0, v0);
      check($sformatf("vector %0d R1/R3/R4/R7/R8", i), r0, VEC[i].exp, v0, VEC[i].drv);
    end

    // R2 deselected write (ce1 low) leaves word 0 untouched, R7 no drive
    @(negedge clk[0]);
    ce1[0] = 1'b0; rnw[0] = 1'b0; addr[0] = 10'h000; lane_n[0] = 2'b00; wdata[0] = '0;
    @(negedge clk[0]); r0 = rdata[0]; v0 = rdrv[0]; idle_port(0);
    check("R7 deselected", r0, '0, v0, 2'b00);
    run_op(0, 1'b0, 10'h000, 2'b00, '0, r0, v0);
    check("R2 ce1 deselect", r0, 18'h3FFFF, v0, 2'b11);

    // R2 deselect through ce0
    @(negedge clk[1]);
    ce0_n[1] = 1'b1; rnw[1] = 1'b0; addr[1] = 10'h000; lane_n[1] = 2'b00; wdata[1] = 18'h12345;
    @(negedge clk[1]); idle_port(1);
    run_op(1, 1'b0, 10'h000, 2'b00, '0, r0, v0);
    check("R2 ce0 deselect", r0, 18'h3FFFF, v0, 2'b11);

    // R5 read on the edge right after a deselected edge is not driven
    @(negedge clk[2]);
    ce0_n[2] = 1'b1; rnw[2] = 1'b1; addr[2] = 10'h3FF; lane_n[2] = 2'b00;
    @(negedge clk[2]);
    ce0_n[2] = 1'b0;
    @(negedge clk[2]); r0 = rdata[2]; v0 = rdrv[2];
    check("R5 wake cycle", r0, '0, v0, 2'b00);
    @(negedge clk[2]); r0 = rdata[2]; v0 = rdrv[2]; idle_port(2);
    check("R5 after wake", r0, 18'h15555, v0, 2'b11);

    // R6 output enable acts without a clock
    oe_n[3] = 1'b1;
    run_op(3, 1'b0, 10'h000, 2'b00, '0, r0, v0);
    check("R6 oe high", r0, '0, v0, 2'b00);
    oe_n[3] = 1'b0; #1;
    check("R6 oe low", rdata[3], 18'h3FFFF, rdrv[3], 2'b11);

    // R8 all four ports read one word together
    fork
      run_op(0, 1'b0, 10'h3FF, 2'b00, '0, r0, v0);
      run_op(1, 1'b0, 10'h3FF, 2'b00, '0, r1, v1);
      run_op(2, 1'b0, 10'h3FF, 2'b00, '0, r2, v2);
      run_op(3, 1'b0, 10'h3FF, 2'b00, '0, r3, v3);
    join
    check("R8 shared read p0", r0, 18'h15555, v0, 2'b11);
    check("R8 shared read p1", r1, 18'h15555, v1, 2'b11);
    check("R8 shared read p2", r2, 18'h15555, v2, 2'b11);
    check("R8 shared read p3", r3, 18'h15555, v3, 2'b11);

    // R8 concurrent writes to distinct words, read back through other ports
    fork
      run_op(0, 1'b1, 10'h010, 2'b00, 18'h11111, r0, v0);
      run_op(1, 1'b1, 10'h011, 2'b00, 18'h22222, r1, v1);
      run_op(2, 1'b1, 10'h012, 2'b00, 18'h33333, r2, v2);
      run_op(3, 1'b1, 10'h013, 2'b00, 18'h04444, r3, v3);
    join
    run_op(1, 1'b0, 10'h010, 2'b00, '0, r0, v0);
    check("R8 p0 word via p1", r0, 18'h11111, v0, 2'b11);
    run_op(2, 1'b0, 10'h011, 2'b00, '0, r0, v0);
    check("R8 p1 word via p2", r0, 18'h22222, v0, 2'b11);
    run_op(3, 1'b0, 10'h012, 2'b00, '0, r0, v0);
    check("R8 p2 word via p3", r0, 18'h33333, v0, 2'b11);
    run_op(0, 1'b0, 10'h013, 2'b00, '0, r0, v0);
    check("R8 p3 word via p0", r0, 18'h04444, v0, 2'b11);

    // R9 two ports write word 7 together; only that word is left undefined
    fork
      run_op(0, 1'b1, 10'h007, 2'b00, 18'h2AAAA, r0, v0);
      run_op(1, 1'b1, 10'h007, 2'b00, 18'h15555, r1, v1);
    join
    run_op(2, 1'b0, 10'h006, 2'b00, '0, r0, v0);
    check("R9 word below", r0, 18'h0ABCD, v0, 2'b11);
    run_op(2, 1'b0, 10'h008, 2'b00, '0, r0, v0);
    check("R9 word above", r0, 18'h1F00F, v0, 2'b11);
    if (!tainted.exists(7)) begin
      run_op(3, 1'b0, 10'h007, 2'b00, '0, r0, v0);
      check("R9 word untainted", r0, 18'h15555, v0, 2'b11);
    end

    finish_run();
  end
endmodule